// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block chooses the value of one source operand for the instruction sitting in the decode stage of an in-order pipeline. It compares the operand's register index against the results still travelling through the two later stages (memory access, then writeback). If one of them holds a newer value for that register, the block bypasses it to decode. If nothing matches, it passes the register-file read through unchanged. A decode stage with two source ports uses two copies.

Each later stage can supply three kinds of value. The first is its ALU/result value when the stage's destination index matches. The second is the post-incremented base register of an auto-increment store, which is carried in its second source field. The third is the post-incremented base register of an auto-increment load, carried in its first source field. A load's destination value is not bypassed from the memory stage, because the memory read has not yet produced it there. From writeback it is bypassed like any other result. Whenever a value is bypassed, the block raises a flag and reports the register index, so the scoreboard can clear that register's busy bit. The block is purely combinational.

Top module: `opnd_bypass_sel`

## Requirements
- R1: When no valid stage produces a match, `opnd` equals `rf_val`, `fwd_hit` is 0 and `clr_idx` is 0.
- R2: When both stages match, the memory-stage value is chosen. Writeback is used only when the memory stage gives no match.
- R3: A valid memory stage whose opcode is neither LOAD (4'h6) nor LOADP (4'h7), and whose `mem_rd` equals `src_idx`, supplies `mem_result`.
- R4: A memory-stage LOAD (4'h6) or LOADP (4'h7) never supplies `mem_result` through its destination match. Selection then moves on to the base-register checks, then writeback, then the register file.
- R5: In either stage, a STOREP (4'h9) whose second source index equals `src_idx` supplies that stage's `*_rs2_upd`.
- R6: In either stage, a LOADP (4'h7) whose first source index equals `src_idx` supplies that stage's `*_rs1_upd`.
- R7: Within one stage, a destination match wins over the STOREP base match, and the STOREP base match wins over the LOADP base match.
- R8: A valid writeback stage whose `wb_rd` equals `src_idx` supplies `wb_result` for every opcode, loads included.
- R9: A stage whose valid flag is 0 never supplies a value, whatever its other inputs hold.
- R10: When `fwd_hit` is 1, `clr_idx` equals `src_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_idx | input | 4 | Source register index in decode |
| rf_val | input | DW | Register-file read value |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_op | input | 4 | Memory-stage opcode |
| mem_rd | input | 4 | Memory-stage destination index |
| mem_result | input | DW | Memory-stage result value |
| mem_rs1 | input | 4 | Memory-stage first source index |
| mem_rs1_upd | input | DW | Memory-stage updated first-source value |
| mem_rs2 | input | 4 | Memory-stage second source index |
| mem_rs2_upd | input | DW | Memory-stage updated second-source value |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_op | input | 4 | Writeback-stage opcode |
| wb_rd | input | 4 | Writeback-stage destination index |
| wb_result | input | DW | Writeback-stage result value |
| wb_rs1 | input | 4 | Writeback-stage first source index |
| wb_rs1_upd | input | DW | Writeback-stage updated first-source value |
| wb_rs2 | input | 4 | Writeback-stage second source index |
| wb_rs2_upd | input | DW | Writeback-stage updated second-source value |
| opnd | output | DW | Selected operand value |
| fwd_hit | output | 1 | A later stage supplied the value |
| clr_idx | output | 4 | Register whose busy bit may be cleared |

## Verification
The hardest case to reach is a memory-stage load whose destination and base fields all alias the decode index, while writeback matches as well. Only that combination shows whether the load exclusion passes control to the correct next candidate. The bench sweeps every opcode pair across the two stages, all four valid combinations and all 64 patterns of which index fields equal `src_idx`. Each stage value is a distinct constant, so every wrong selection is visible at `opnd`.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  localparam int IDXW = 4;
  localparam int OPW  = 4;

  localparam logic [OPW-1:0] OPC_LOAD   = 4'h6;
  localparam logic [OPW-1:0] OPC_LOADP  = 4'h7;
  localparam logic [OPW-1:0] OPC_STOREP = 4'h9;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_DEST  = 2'd1,
    SRC_SBASE = 2'd2,
    SRC_LBASE = 2'd3
  } src_kind_e;

  function automatic logic is_load(input logic [OPW-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_LOADP);
  endfunction

  function automatic logic dest_allowed(input logic [OPW-1:0] op, input logic early);
    return !(early && is_load(op));
  endfunction
endpackage

// File: rtl/opnd_stage_probe.sv
module opnd_stage_probe
  import opnd_bypass_pkg::*;
#(
  parameter int DW    = 32,
  parameter bit EARLY = 1'b0
) (
  input  logic [IDXW-1:0] src_idx,
  input  logic            valid,
  input  logic [OPW-1:0]  op,
  input  logic [IDXW-1:0] rd,
  input  logic [DW-1:0]   result,
  input  logic [IDXW-1:0] rs1,
  input  logic [DW-1:0]   rs1_upd,
  input  logic [IDXW-1:0] rs2,
  input  logic [DW-1:0]   rs2_upd,
  output logic            hit,
  output src_kind_e       kind,
  output logic [DW-1:0]   val
);
  logic dest_ok;

  generate
    if (EARLY) begin : g_early
      assign dest_ok = dest_allowed(op, 1'b1);
    end else begin : g_late
      assign dest_ok = 1'b1;
    end
  endgenerate

  logic m_dest, m_sbase, m_lbase;
  assign m_dest  = valid && dest_ok && (rd == src_idx);
  assign m_sbase = valid && (op == OPC_STOREP) && (rs2 == src_idx);
  assign m_lbase = valid && (op == OPC_LOADP)  && (rs1 == src_idx);

  always_comb begin
    if (m_dest)       kind = SRC_DEST;
    else if (m_sbase) kind = SRC_SBASE;
    else if (m_lbase) kind = SRC_LBASE;
    else              kind = SRC_NONE;
  end

  always_comb begin
    unique case (kind)
      SRC_DEST:  val = result;
      SRC_SBASE: val = rs2_upd;
      SRC_LBASE: val = rs1_upd;
      default:   val = '0;
    endcase
  end

  assign hit = (kind != SRC_NONE);
endmodule

// File: rtl/opnd_bypass_sel.sv
module opnd_bypass_sel
  import opnd_bypass_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    src_idx,
  input  logic [DW-1:0] rf_val,
  input  logic          mem_valid,
  input  logic [3:0]    mem_op,
  input  logic [3:0]    mem_rd,
  input  logic [DW-1:0] mem_result,
  input  logic [3:0]    mem_rs1,
  input  logic [DW-1:0] mem_rs1_upd,
  input  logic [3:0]    mem_rs2,
  input  logic [DW-1:0] mem_rs2_upd,
  input  logic          wb_valid,
  input  logic [3:0]    wb_op,
  input  logic [3:0]    wb_rd,
  input  logic [DW-1:0] wb_result,
  input  logic [3:0]    wb_rs1,
  input  logic [DW-1:0] wb_rs1_upd,
  input  logic [3:0]    wb_rs2,
  input  logic [DW-1:0] wb_rs2_upd,
  output logic [DW-1:0] opnd,
  output logic          fwd_hit,
  output logic [3:0]    clr_idx
);
  logic            mem_hit, wb_hit;
  src_kind_e       mem_kind, wb_kind;
  logic [DW-1:0]   mem_val, wb_val;

  opnd_stage_probe #(.DW(DW), .EARLY(1'b1)) u_mem (
    .src_idx(src_idx), .valid(mem_valid), .op(mem_op), .rd(mem_rd),
    .result(mem_result), .rs1(mem_rs1), .rs1_upd(mem_rs1_upd),
    .rs2(mem_rs2), .rs2_upd(mem_rs2_upd),
    .hit(mem_hit), .kind(mem_kind), .val(mem_val)
  );

  opnd_stage_probe #(.DW(DW), .EARLY(1'b0)) u_wb (
    .src_idx(src_idx), .valid(wb_valid), .op(wb_op), .rd(wb_rd),
    .result(wb_result), .rs1(wb_rs1), .rs1_upd(wb_rs1_upd),
    .rs2(wb_rs2), .rs2_upd(wb_rs2_upd),
    .hit(wb_hit), .kind(wb_kind), .val(wb_val)
  );

  always_comb begin
    if (mem_hit)     opnd = mem_val;
    else if (wb_hit) opnd = wb_val;
    else             opnd = rf_val;
  end

  assign fwd_hit = mem_hit || wb_hit;
  assign clr_idx = fwd_hit ? src_idx : '0;
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk
  import opnd_bypass_pkg::*;
#(
  parameter int DW = 32
) (
  input logic [3:0]    src_idx,
  input logic [DW-1:0] rf_val,
  input logic          mem_valid,
  input logic [3:0]    mem_op,
  input logic          wb_valid,
  input logic          mem_hit,
  input logic          wb_hit,
  input src_kind_e     mem_kind,
  input logic [DW-1:0] mem_val,
  input logic [DW-1:0] wb_val,
  input logic [DW-1:0] opnd,
  input logic          fwd_hit,
  input logic [3:0]    clr_idx
);
  always_comb begin
    if (!mem_valid && !wb_valid)
      AST_IDLE_STAGES: assert (opnd == rf_val && !fwd_hit); // R9
    if (!fwd_hit)
      AST_RF_FALLBACK: assert (opnd == rf_val && clr_idx == '0); // R1
    if (mem_hit)
      AST_MEM_FIRST: assert (opnd == mem_val); // R2
    if (!mem_hit && wb_hit)
      AST_WB_SECOND: assert (opnd == wb_val); // R8
    if (mem_valid && mem_op == OPC_LOAD)
      AST_NO_EARLY_LOAD: assert (!mem_hit); // R4
    if (mem_valid && mem_op == OPC_LOADP)
      AST_LOADP_BASE_ONLY: assert (mem_kind == SRC_NONE || mem_kind == SRC_LBASE); // R6
    if (fwd_hit)
      AST_CLEAR_INDEX: assert (clr_idx == src_idx); // R10
  end
endmodule

bind opnd_bypass_sel opnd_bypass_chk #(.DW(DW)) u_chk (
  .src_idx(src_idx), .rf_val(rf_val), .mem_valid(mem_valid), .mem_op(mem_op),
  .wb_valid(wb_valid), .mem_hit(mem_hit), .wb_hit(wb_hit), .mem_kind(mem_kind),
  .mem_val(mem_val), .wb_val(wb_val), .opnd(opnd), .fwd_hit(fwd_hit),
  .clr_idx(clr_idx)
);

// File: tb/opnd_bypass_sel_test.sv
module opnd_bypass_sel_test;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]    src_idx;
  logic [DW-1:0] rf_val;
  logic          mem_valid, wb_valid;
  logic [3:0]    mem_op, mem_rd, mem_rs1, mem_rs2;
  logic [3:0]    wb_op, wb_rd, wb_rs1, wb_rs2;
  logic [DW-1:0] mem_result, mem_rs1_upd, mem_rs2_upd;
  logic [DW-1:0] wb_result, wb_rs1_upd, wb_rs2_upd;
  logic [DW-1:0] opnd;
  logic          fwd_hit;
  logic [3:0]    clr_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  opnd_bypass_sel #(.DW(DW)) uut (
    .src_idx(src_idx), .rf_val(rf_val),
    .mem_valid(mem_valid), .mem_op(mem_op), .mem_rd(mem_rd), .mem_result(mem_result),
    .mem_rs1(mem_rs1), .mem_rs1_upd(mem_rs1_upd), .mem_rs2(mem_rs2), .mem_rs2_upd(mem_rs2_upd),
    .wb_valid(wb_valid), .wb_op(wb_op), .wb_rd(wb_rd), .wb_result(wb_result),
    .wb_rs1(wb_rs1), .wb_rs1_upd(wb_rs1_upd), .wb_rs2(wb_rs2), .wb_rs2_upd(wb_rs2_upd),
    .opnd(opnd), .fwd_hit(fwd_hit), .clr_idx(clr_idx)
  );

  // Reference model: candidates ordered by priority, first taken wins.
  task automatic model(output logic [DW-1:0] ev, output logic eh, output string tag);
    ev = rf_val; eh = 1'b0; tag = "R1";
    if (wb_valid) begin
      if (wb_op == 4'h7 && wb_rs1 == src_idx) begin ev = wb_rs1_upd; eh = 1; tag = "R6"; end
      if (wb_op == 4'h9 && wb_rs2 == src_idx) begin ev = wb_rs2_upd; eh = 1; tag = "R5"; end
      if (wb_rd == src_idx) begin ev = wb_result; eh = 1; tag = "R8"; end
    end
    if (mem_valid) begin
      if (mem_op == 4'h7 && mem_rs1 == src_idx) begin ev = mem_rs1_upd; eh = 1; tag = "R6"; end
      if (mem_op == 4'h9 && mem_rs2 == src_idx) begin ev = mem_rs2_upd; eh = 1; tag = "R5"; end
      if (mem_rd == src_idx && mem_op != 4'h6 && mem_op != 4'h7) begin
        ev = mem_result; eh = 1; tag = "R3";
      end
    end
  endtask

  task automatic check(input string tag, input logic [DW-1:0] ev, input logic eh);
    checks++;
    if (opnd !== ev || fwd_hit !== eh || clr_idx !== (eh ? src_idx : 4'd0)) begin
      errors++;
      $display("FAIL %s opnd=%h hit=%b clr=%0d expected opnd=%h hit=%b clr=%0d",
               tag, opnd, fwd_hit, clr_idx, ev, eh, eh ? src_idx : 4'd0);
    end
  endtask

  initial begin
    logic [DW-1:0] ev;
    logic eh;
    string tag;
    src_idx = 4'd5; rf_val = 32'hAAAA_0001;
    mem_result = 32'h1111_0001; mem_rs1_upd = 32'h1111_0002; mem_rs2_upd = 32'h1111_0003;
    wb_result  = 32'h2222_0001; wb_rs1_upd  = 32'h2222_0002; wb_rs2_upd  = 32'h2222_0003;
    mem_valid = 0; wb_valid = 0; mem_op = 0; wb_op = 0;
    mem_rd = 5; mem_rs1 = 5; mem_rs2 = 5; wb_rd = 5; wb_rs1 = 5; wb_rs2 = 5;
    #5;
    check("R9", rf_val, 1'b0); // both stages invalid, all fields alias

    // Directed: memory LOAD on dest defers to writeback (R4, R2)
    mem_valid = 1; mem_op = 4'h6; wb_valid = 1; wb_op = 4'h6; mem_rs1 = 1; mem_rs2 = 2;
    #2; check("R4", wb_result, 1'b1);
    // STOREP in memory: dest beats base (R7)
    mem_op = 4'h9; mem_rs2 = 5; #2; check("R7", mem_result, 1'b1);

    for (int mo = 0; mo < 16; mo++)
      for (int wo = 0; wo < 16; wo++)
        for (int v = 0; v < 4; v++)
          for (int pat = 0; pat < 64; pat++) begin
            mem_op = 4'(mo); wb_op = 4'(wo);
            mem_valid = v[0]; wb_valid = v[1];
            src_idx = 4'((mo + pat) % 16);
            rf_val  = 32'hAAAA_0000 + 32'(pat);
            mem_rd  = pat[0] ? src_idx : src_idx + 4'd1;
            mem_rs1 = pat[1] ? src_idx : src_idx + 4'd2;
            mem_rs2 = pat[2] ? src_idx : src_idx + 4'd3;
            wb_rd   = pat[3] ? src_idx : src_idx + 4'd4;
            wb_rs1  = pat[4] ? src_idx : src_idx + 4'd5;
            wb_rs2  = pat[5] ? src_idx : src_idx + 4'd6;
            #2;
            model(ev, eh, tag);
            if (v == 0) tag = "R9";
            else if (tag == "R3" && pat[1] && mo == 7) tag = "R7";
            else if (tag != "R1" && !fwd_hit) tag = {tag, "/R10"};
            check(tag, ev, eh);
          end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule